// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull Control

An eight-pin general-purpose I/O port that a small CPU reaches through a flat register bus. The bus has an address, a single-cycle write strobe, write data and combinational read data. Three registers sit behind it: an output-value register, a direction register and a pull-resistor control register. The pin side of the block drives an output value, an output enable per pin, a pull-enable per pin and a slow-edge enable per pin. It also takes the raw pin levels, which it synchronizes before they can be read.

The pull control is active-low: a cleared bit requests the resistor. The resistor is granted only while the pin is an input. The top direction bit serves two purposes. It sets the direction of its own pin, and it also turns on slow output edges for a fixed set of pins chosen by parameter. Reads of the data offset merge two sources: bits of output pins return the latched value, and bits of input pins return the synchronized level.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data, direction and pull registers hold 0. So `pin_o` = 0, `pin_oe_o` = 0, `pull_en_o` = all ones and `slow_en_o` = 0.
- R2: A write to offset 0 loads the data register. `pin_o` shows the new value from the clock edge that takes the write.
- R3: A write to offset 2 loads the direction register. A bit of 1 makes its pin an output (`pin_oe_o` bit = 1), and 0 makes it an input.
- R4: A read of offset 0 returns the data-register bit for each output pin. For each input pin it returns the pin level through a two-flop synchronizer, so a change on `pin_i` appears in `rdata_o` two clock edges later.
- R5: A write to offset 9 loads the pull register. Each `pull_en_o` bit is 1 exactly when its pull bit is 0 and its pin is an input. No output pin ever has its pull enabled.
- R6: Direction bit `SLOW_BIT` (bit 7 by default) is the slow-edge enable. While it is 1, `slow_en_o` equals `SLOW_MASK` (8'hC2 by default, pins 7, 6 and 1). While it is 0, `slow_en_o` is 0.
- R7: Reads of offsets 2 and 9 return the direction and pull registers as last written.
- R8: Any offset other than 0, 2 and 9 reads as 0. A write to such an offset changes no register and no pin-side output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for `addr_i`, combinational |
| pin_i | input | WIDTH | Raw pin levels |
| pin_o | output | WIDTH | Pin output values |
| pin_oe_o | output | WIDTH | Output enable per pin |
| pull_en_o | output | WIDTH | Pull resistor enable per pin |
| slow_en_o | output | WIDTH | Slow-edge enable per pin |

## Verification
The bench builds the port with its defaults: eight pins, a four-bit offset, slow-edge control on bit 7 and the slow mask 8'hC2. The four-bit offset lets the bench reach offsets that differ from live ones by one bit, such as 1, 3, 8 and 11, so the address decode is checked on every bit. Mixed direction patterns make merged reads contain both latched and synchronized bits in the same word. Setting bit 7 alone shows the slow-edge control acting on pins whose own direction bits stay 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 2;
  localparam int unsigned OFS_PULL = 9;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  data_q_o,
  output logic [WIDTH-1:0]  dir_q_o,
  output logic [WIDTH-1:0]  pull_q_o
);
  logic hit_data, hit_dir, hit_pull;

  assign hit_data = we_i && (addr_i == ADDR_W'(OFS_DATA));
  assign hit_dir  = we_i && (addr_i == ADDR_W'(OFS_DIR));
  assign hit_pull = we_i && (addr_i == ADDR_W'(OFS_PULL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
      pull_q_o <= '0;
    end else begin
      if (hit_data) data_q_o <= wdata_i;
      if (hit_dir)  dir_q_o  <= wdata_i;
      if (hit_pull) pull_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  data_q_i,
  input  logic [WIDTH-1:0]  dir_q_i,
  input  logic [WIDTH-1:0]  pull_q_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_DATA))
      rdata_o = (dir_q_i & data_q_i) | (~dir_q_i & pin_sync_i);
    else if (addr_i == ADDR_W'(OFS_DIR))
      rdata_o = dir_q_i;
    else if (addr_i == ADDR_W'(OFS_PULL))
      rdata_o = pull_q_i;
  end
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl #(
  parameter int unsigned       WIDTH     = 8,
  parameter int unsigned       SLOW_BIT  = 7,
  parameter logic [WIDTH-1:0]  SLOW_MASK = WIDTH'(8'hC2)
) (
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] pull_q_i,
  output logic [WIDTH-1:0] pull_en_o,
  output logic [WIDTH-1:0] slow_en_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    // active-low pull request, granted to inputs only
    assign pull_en_o[i] = !pull_q_i[i] && !dir_q_i[i];
    if (SLOW_MASK[i]) begin : g_slow
      assign slow_en_o[i] = dir_q_i[SLOW_BIT];
    end else begin : g_fast
      assign slow_en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter int unsigned      ADDR_W    = 4,
  parameter int unsigned      SLOW_BIT  = 7,
  parameter logic [WIDTH-1:0] SLOW_MASK = WIDTH'(8'hC2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pull_en_o,
  output logic [WIDTH-1:0]  slow_en_o
);
  logic [WIDTH-1:0] data_q, dir_q, pull_q, pin_sync;

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .data_q_o (data_q),
    .dir_q_o  (dir_q),
    .pull_q_o (pull_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_rdmux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i     (addr_i),
    .data_q_i   (data_q),
    .dir_q_i    (dir_q),
    .pull_q_i   (pull_q),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o)
  );

  gpio_pinctl #(.WIDTH(WIDTH), .SLOW_BIT(SLOW_BIT), .SLOW_MASK(SLOW_MASK)) u_pinctl (
    .dir_q_i   (dir_q),
    .pull_q_i  (pull_q),
    .pull_en_o (pull_en_o),
    .slow_en_o (slow_en_o)
  );

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter int unsigned      ADDR_W    = 4,
  parameter int unsigned      SLOW_BIT  = 7,
  parameter logic [WIDTH-1:0] SLOW_MASK = WIDTH'(8'hC2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pin_i,
  input logic [WIDTH-1:0]  pin_o,
  input logic [WIDTH-1:0]  pin_oe_o,
  input logic [WIDTH-1:0]  pull_en_o,
  input logic [WIDTH-1:0]  slow_en_o
);
  logic [1:0] live_cnt;
  logic       addr_used;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assign addr_used = (addr_i == ADDR_W'(OFS_DATA)) || (addr_i == ADDR_W'(OFS_DIR)) ||
                     (addr_i == ADDR_W'(OFS_PULL));

  a_r2_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_DATA)) |=> (pin_o == $past(wdata_i)));

  a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_DIR)) |=> (pin_oe_o == $past(wdata_i)));

  a_r4_input_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt >= 2'd2 && addr_i == ADDR_W'(OFS_DATA)) |->
      ((rdata_o & ~pin_oe_o) == ($past(pin_i, 2) & ~pin_oe_o)));

  a_r4_output_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_DATA)) |-> ((rdata_o & pin_oe_o) == (pin_o & pin_oe_o)));

  a_r5_no_pull_on_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pin_oe_o) == '0);

  a_r6_slow_off_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_en_o & ~SLOW_MASK) == '0);

  a_r8_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_used |-> (rdata_o == '0));

  a_r8_unused_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_used) |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(pull_en_o)));
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SLOW_BIT(SLOW_BIT), .SLOW_MASK(SLOW_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .pull_en_o(pull_en_o), .slow_en_o(slow_en_o)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int unsigned W = 8;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  pins = '0;
  logic [W-1:0]  rdata, pin_out, pin_oe, pull_en, slow_en;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .pull_en_o(pull_en), .slow_en_o(slow_en)
  );

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req, logic [W-1:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, $sformatf("read @%0d", a), rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1", "pin_o", pin_out, 8'h00);
    chk("R1", "pin_oe_o", pin_oe, 8'h00);
    chk("R1", "pull_en_o", pull_en, 8'hFF);
    chk("R1", "slow_en_o", slow_en, 8'h00);
    rd(4'd2, "R1", 8'h00);
    rd(4'd9, "R1", 8'h00);
  endtask

  task automatic t_data_dir();
    wr(4'd0, 8'hA5);
    chk("R2", "pin_o", pin_out, 8'hA5);
    wr(4'd2, 8'h0F);
    chk("R3", "pin_oe_o", pin_oe, 8'h0F);
    rd(4'd2, "R7", 8'h0F);
    wr(4'd0, 8'h5A);
    chk("R2", "pin_o second", pin_out, 8'h5A);
  endtask

  task automatic t_mixed_read();
    // dir 0x0F, data 0x5A: low nibble latched, high nibble from pins
    @(negedge clk); pins = 8'h3C; addr = 4'd0;
    @(negedge clk); #1;
    chk("R4", "one edge after pin change", rdata, 8'h0A);
    @(negedge clk); #1;
    chk("R4", "two edges after pin change", rdata, 8'h3A);
    @(negedge clk); pins = 8'hC3;
    @(negedge clk); @(negedge clk); #1;
    chk("R4", "second pattern", rdata, 8'hCA);
    wr(4'd2, 8'hF0);
    rd(4'd0, "R4", 8'h53);
  endtask

  task automatic t_pull();
    wr(4'd2, 8'h0F);
    wr(4'd9, 8'h33);
    chk("R5", "pull_en_o mixed", pull_en, 8'hC0);
    rd(4'd9, "R7", 8'h33);
    wr(4'd2, 8'h00);
    chk("R5", "pull_en_o all inputs", pull_en, 8'hCC);
    wr(4'd9, 8'h00);
    wr(4'd2, 8'hFF);
    chk("R5", "pull_en_o all outputs", pull_en, 8'h00);
  endtask

  task automatic t_slow();
    wr(4'd2, 8'h80);
    chk("R6", "slow_en_o set", slow_en, 8'hC2);
    chk("R3", "pin_oe_o bit7", pin_oe, 8'h80);
    wr(4'd2, 8'h7F);
    chk("R6", "slow_en_o clear", slow_en, 8'h00);
  endtask

  task automatic t_unused();
    logic [W-1:0] p0, o0, u0;
    wr(4'd0, 8'h96);
    wr(4'd2, 8'h3C);
    wr(4'd9, 8'h81);
    p0 = pin_out; o0 = pin_oe; u0 = pull_en;
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2 && a != 9) begin
        wr(AW'(a), 8'hFF);
        rd(AW'(a), "R8", 8'h00);
      end
    end
    chk("R8", "pin_o after unused writes", pin_out, p0);
    chk("R8", "pin_oe_o after unused writes", pin_oe, o0);
    chk("R8", "pull_en_o after unused writes", pull_en, u0);
    rd(4'd2, "R8", 8'h3C);
    rd(4'd9, "R8", 8'h81);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_data_dir();
    t_mixed_read();
    t_pull();
    t_slow();
    t_unused();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule